// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Unit

This block gathers the event pulses of a serial port (receive path, transmit path and modem-line logic) into one interrupt request line. Each of thirteen sources owns one bit of a sticky status register. That bit latches whenever its source pulses for a cycle, whether or not the source is enabled. A mask register selects which latched bits may drive the request line.

Software reaches the unit through a small register bus: an address, write data of one interrupt field in width, a write strobe, and combinational read data. The mask has no direct write port. It is changed only through two write-only ports. One sets the mask bits written as ones and the other clears them, so software can enable or disable one source without a read-modify-write. The status register is cleared by writing ones: each bit written as one is cleared, and each bit written as zero is left alone.

Top module: `uart_irq_unit`

## Requirements
- R1: After a synchronous active-high reset, the mask and status registers both read 0 and `irq_o` is low.
- R2: Each of the 13 sources owns one status bit. From bit 0 upward the bits are: rx trigger, rx empty, rx full, tx empty, tx full, rx overflow, framing error, parity error, rx timeout, modem status change, tx trigger, tx nearly full and tx overflow. A one-cycle pulse on `evt_i[i]` sets status bit i on the next clock edge, regardless of the mask.
- R3: A write to the enable port at offset 0x08 sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: A write to the disable port at offset 0x0C clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R5: The mask reads back at offset 0x10. A write to offset 0x10 leaves the mask and the status unchanged.
- R6: The status reads back at offset 0x14. A write there clears each status bit written as 1 and leaves each bit written as 0 unchanged. A status bit stays set until it is cleared this way or by reset.
- R7: When a source pulse and a write-one-to-clear of the same status bit fall in the same cycle, the bit is set after the edge.
- R8: `irq_o` is high exactly when at least one status bit is set whose mask bit is also set. It follows the registers with no added cycle.
- R9: Reads of the enable port, the disable port and any unmapped offset return 0.
- R10: A write of 0x1FFF reaches all 13 sources at once: it enables, disables or clears every bit, depending on the port it is written to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (6) | Byte offset of the register accessed |
| bus_wdata | input | NSRC (13) | Write data, one bit per source |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | NSRC (13) | Read data for `bus_addr`, combinational |
| evt_i | input | NSRC (13) | One-cycle event pulses, one per source |
| irq_o | output | 1 | Interrupt request |

## Verification
Some rules are checked on every clock edge: a pulse latches its status bit, a latched bit holds while no status write occurs, the set and clear ports change only the bits written as ones, the mask holds on all other writes, an enabled pending source raises the request line, and the write-only ports read as zero. Other behaviour is shown only by the bench scenarios: the exact bit positions and offsets seen from software, the rule that an event wins over a clear in the same cycle, the all-bits write of 0x1FFF, and long mixed sequences of writes and events checked against an arithmetic model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    // Number of event sources fed into the unit.
    localparam int unsigned SRC_COUNT = 13;

    // Register offsets seen on the bus.
    localparam int unsigned OFF_EN   = 'h08;
    localparam int unsigned OFF_DIS  = 'h0C;
    localparam int unsigned OFF_MASK = 'h10;
    localparam int unsigned OFF_STAT = 'h14;

    // Source positions inside every interrupt field.
    typedef enum int unsigned {
        SRC_RX_TRIG     = 0,
        SRC_RX_EMPTY    = 1,
        SRC_RX_FULL     = 2,
        SRC_TX_EMPTY    = 3,
        SRC_TX_FULL     = 4,
        SRC_RX_OVF      = 5,
        SRC_FRAME_ERR   = 6,
        SRC_PARITY_ERR  = 7,
        SRC_RX_TIMEOUT  = 8,
        SRC_MODEM_DELTA = 9,
        SRC_TX_TRIG     = 10,
        SRC_TX_NEAR     = 11,
        SRC_TX_OVF      = 12
    } src_pos_e;

    // Which register the current address selects.
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_EN   = 3'd1,
        SEL_DIS  = 3'd2,
        SEL_MASK = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    // Qualified write actions derived from one bus cycle.
    typedef struct packed {
        logic do_set;
        logic do_clr;
        logic do_ack;
    } wr_act_t;

    function automatic wr_act_t act_of(input reg_sel_e sel, input logic we);
        wr_act_t a;
        a.do_set = we && (sel == SEL_EN);
        a.do_clr = we && (sel == SEL_DIS);
        a.do_ack = we && (sel == SEL_STAT);
        return a;
    endfunction

endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
    import uirq_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    output reg_sel_e      sel,
    output wr_act_t       act
);

    always_comb begin
        if (addr == AW'(OFF_EN)) begin
            sel = SEL_EN;
        end else if (addr == AW'(OFF_DIS)) begin
            sel = SEL_DIS;
        end else if (addr == AW'(OFF_MASK)) begin
            sel = SEL_MASK;
        end else if (addr == AW'(OFF_STAT)) begin
            sel = SEL_STAT;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign act = act_of(sel, we);

endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg #(
    parameter int unsigned NSRC = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_bits,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] mask_q
);

    // Set dominates clear if both ever name the same bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q & ~clr_bits) | set_bits;
        end
    end

endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
    parameter int unsigned NSRC = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] ack_bits,
    output logic [NSRC-1:0] stat_q
);

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[g] <= 1'b0;
            end else if (evt[g]) begin
                stat_q[g] <= 1'b1;
            end else if (ack_bits[g]) begin
                stat_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uirq_rdmux.sv
module uirq_rdmux
    import uirq_pkg::*;
#(
    parameter int unsigned NSRC = 13
) (
    input  reg_sel_e        sel,
    input  logic [NSRC-1:0] mask_q,
    input  logic [NSRC-1:0] stat_q,
    output logic [NSRC-1:0] rdata
);

    always_comb begin
        case (sel)
            SEL_MASK: rdata = mask_q;
            SEL_STAT: rdata = stat_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uirq_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT,
    parameter int unsigned AW   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    input  logic            bus_we,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] evt_i,
    output logic            irq_o
);

    reg_sel_e        sel;
    wr_act_t         act;
    logic [NSRC-1:0] set_bits;
    logic [NSRC-1:0] clr_bits;
    logic [NSRC-1:0] ack_bits;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] stat_q;

    uirq_decode #(.AW(AW)) dec_i (
        .addr (bus_addr),
        .we   (bus_we),
        .sel  (sel),
        .act  (act)
    );

    assign set_bits = act.do_set ? bus_wdata : '0;
    assign clr_bits = act.do_clr ? bus_wdata : '0;
    assign ack_bits = act.do_ack ? bus_wdata : '0;

    uirq_mask_reg #(.NSRC(NSRC)) mask_i (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .mask_q   (mask_q)
    );

    uirq_sticky #(.NSRC(NSRC)) stat_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_i),
        .ack_bits (ack_bits),
        .stat_q   (stat_q)
    );

    uirq_rdmux #(.NSRC(NSRC)) rd_i (
        .sel    (sel),
        .mask_q (mask_q),
        .stat_q (stat_q),
        .rdata  (bus_rdata)
    );

    assign irq_o = |(stat_q & mask_q);

endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk
    import uirq_pkg::*;
#(
    parameter int unsigned NSRC = SRC_COUNT,
    parameter int unsigned AW   = 6
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic [NSRC-1:0] bus_wdata,
    input logic            bus_we,
    input logic [NSRC-1:0] bus_rdata,
    input logic [NSRC-1:0] evt_i,
    input logic            irq_o,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] stat_q
);

    logic wr_en, wr_dis, wr_stat;
    assign wr_en   = bus_we && (bus_addr == AW'(OFF_EN));
    assign wr_dis  = bus_we && (bus_addr == AW'(OFF_DIS));
    assign wr_stat = bus_we && (bus_addr == AW'(OFF_STAT));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (mask_q == '0) && (stat_q == '0));

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && (evt_i == '0)) |=> ((stat_q & $past(bus_wdata)) == '0));

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R4
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dis |=> ((mask_q & $past(bus_wdata)) == '0));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en || wr_dis) |=> $stable(mask_q));

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && ((evt_i & mask_q) != '0)) |=> irq_o);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_o);

    // R9
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == AW'(OFF_EN)) || (bus_addr == AW'(OFF_DIS))) |-> (bus_rdata == '0));

endmodule

bind uart_irq_unit uart_irq_unit_chk #(.NSRC(NSRC), .AW(AW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .stat_q    (stat_q)
);

// File: tb/uart_irq_unit_tb_top.sv
`timescale 1ns/1ps
module uart_irq_unit_tb_top;

    localparam int N  = 13;
    localparam int AW = 6;
    localparam logic [N-1:0] ALL = 13'h1FFF;
    localparam logic [AW-1:0] A_EN   = 6'h08;
    localparam logic [AW-1:0] A_DIS  = 6'h0C;
    localparam logic [AW-1:0] A_MASK = 6'h10;
    localparam logic [AW-1:0] A_STAT = 6'h14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  evt_i = '0;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] m_mask = '0;
    logic [N-1:0] m_stat = '0;
    logic [31:0]  seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    uart_irq_unit #(.NSRC(N), .AW(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .evt_i     (evt_i),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle plus events; the model follows the requirements.
    task automatic step(input logic we, input logic [AW-1:0] a, input logic [N-1:0] wd,
                        input logic [N-1:0] ev);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; evt_i = ev;
        @(negedge clk);
        bus_we = 1'b0; evt_i = '0;
        if (we && a == A_EN)   m_mask = m_mask | wd;
        if (we && a == A_DIS)  m_mask = m_mask & ~wd;
        if (we && a == A_STAT) m_stat = m_stat & ~wd;
        m_stat = m_stat | ev;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [N-1:0] v;
        rd(A_MASK, v); check({req, " mask"}, v, m_mask);
        rd(A_STAT, v); check({req, " status"}, v, m_stat);
        check({req, " irq"}, N'(irq_o), N'(|(m_mask & m_stat)));
    endtask

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_all("R1");

        // R2 R3 R4 R6 R8 sweep over every source bit
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            step(1'b0, A_MASK, '0, b);            check_all("R2");
            check("R8 masked irq", N'(irq_o), '0);
            step(1'b1, A_EN, b, '0);              check_all("R3");
            check("R8 enabled irq", N'(irq_o), N'(1));
            step(1'b1, A_STAT, '0, '0);           check_all("R6 zero write");
            step(1'b1, A_STAT, b, '0);            check_all("R6 clear");
            step(1'b1, A_DIS, b, '0);             check_all("R4");
        end

        // R3 accumulation, zeros leave bits alone; R5 ignored write
        step(1'b1, A_EN, 13'h0005, '0);           check_all("R3 acc");
        step(1'b1, A_EN, 13'h0A00, '0);           check_all("R3 acc");
        step(1'b1, A_MASK, '0, '0);               check_all("R5");
        step(1'b1, A_MASK, ALL, '0);              check_all("R5");
        step(1'b1, A_DIS, 13'h0004, '0);          check_all("R4 partial");

        // R9 write-only and unmapped reads
        rd(A_EN, v);  check("R9 en read", v, '0);
        rd(A_DIS, v); check("R9 dis read", v, '0);
        rd(6'h00, v); check("R9 unmapped read", v, '0);
        rd(6'h30, v); check("R9 unmapped read", v, '0);

        // R7 event beats clear of the same bit
        step(1'b0, A_MASK, '0, 13'h0100);         check_all("R7 pre");
        step(1'b1, A_STAT, 13'h0101, 13'h0100);   check_all("R7");
        rd(A_STAT, v); check("R7 bit stays", v & 13'h0100, 13'h0100);

        // R10 all-bits writes
        step(1'b1, A_EN, ALL, '0);                check_all("R10 en");
        step(1'b0, A_MASK, '0, ALL);              check_all("R10 events");
        step(1'b1, A_STAT, ALL, '0);              check_all("R10 clear");
        step(1'b0, A_MASK, '0, 13'h1555);         check_all("R10 refill");
        step(1'b1, A_DIS, ALL, '0);               check_all("R10 dis");
        check("R10 irq off", N'(irq_o), '0);

        // Mixed sequences against the model
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            logic [N-1:0] wd, ev;
            seed = seed * 32'd1664525 + 32'd1013904223;
            case (seed[31:29])
                3'd0, 3'd1: a = A_EN;
                3'd2, 3'd3: a = A_DIS;
                3'd4, 3'd5: a = A_STAT;
                3'd6:       a = A_MASK;
                default:    a = 6'h2C;
            endcase
            wd = seed[N-1:0];
            seed = seed * 32'd1664525 + 32'd1013904223;
            ev = seed[28:16] & seed[12:0];
            step(seed[30], a, wd, ev);
            check_all("R2 R3 R4 R6 R7 R8 mixed");
        end

        // R1 reset again from a busy state
        step(1'b1, A_EN, ALL, ALL);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_mask = '0; m_stat = '0;
        check_all("R1 rereset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule